// File: doc/BRIEF.md
# External Status Interrupt Latch

This block gathers four external/status conditions of a serial channel and turns them into one interrupt request and a readable status byte. The four conditions are a line break or frame abort level coming from the receiver, a transmit underrun / end-of-message latch, a clear-to-send pin and a sync/hunt pin. Each condition has its own enable. A single pending flag drives the interrupt request. While that flag is set, the status of every enabled level source stays frozen, so software reads one consistent snapshot.

Software services the interrupt by reading the status byte and then issuing a release command. The release clears the pending flag and takes a fresh sample of every level. A condition that changed while the flag was set may raise the interrupt again at once. Each source decides this by its own rule:
- Both pins re-raise only after an odd number of transitions.
- The break/abort level re-raises after any transition.
- The underrun latch re-raises only for a 0-to-1 change.

The two pins pass through a two-flop synchronizer. The break/abort level and all commands are already in the block's clock domain.

Top module: `xstat_irq_latch`

## Requirements
- R1: After reset, with the clear-to-send and sync pins high and the break/abort level low, `irq` is 0 and `stat_byte` is 8'h70. The status layout is: bit 7 break/abort, bit 6 underrun, bit 5 clear-to-send, bit 4 sync. Bits 3:0 always read 0.
- R2: With the clear-to-send enable set and no interrupt pending, a change on `cts_pin` latches the new pin level into bit 5 and raises `irq`. Both happen on the third rising clock edge after the pin changes.
- R3: While `irq` is set, status bits 7, 5 and 4 of enabled sources hold the values they had when the interrupt was taken, whatever the sources do.
- R4: If `cts_pin` toggles an odd number of times while an interrupt is pending, the release command leaves `irq` set and bit 5 shows the new level. An even number of toggles lets `irq` drop.
- R5: With the clear-to-send enable cleared, bit 5 follows the synchronized pin two clock edges after a change, and no change raises `irq`.
- R6: With its enable set, both a rising and a falling edge of `brk_lvl` raise `irq` on the next clock edge. Any break/abort edge seen while an interrupt is pending makes `irq` stay set after the release command, even if the level has returned to its old value.
- R7: The underrun bit (bit 6) is set by reset, `urun_evt`, `tx_disable` and `send_abort_cmd`. It is cleared only by `clr_urun_cmd`. When a set and a clear come in the same cycle, the set wins. Each change is visible one clock edge later.
- R8: Only a 0-to-1 change of the underrun bit raises `irq`, and only while `ie_urun` is set. A set request while the bit is already 1 raises nothing.
- R9: `irq` stays set until `clr_stat_cmd`. On the edge that samples the command, `irq` takes the value of whatever new condition is present, and the frozen bits are re-sampled from their live sources.
- R10: The sync pin follows the rules of R2 to R5, reported in bit 4 and gated by `ie_sync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| brk_lvl | input | 1 | Break/abort condition level from the receiver |
| cts_pin | input | 1 | Clear-to-send pin, asynchronous |
| sync_pin | input | 1 | Sync/hunt pin, asynchronous |
| urun_evt | input | 1 | One-cycle pulse on a transmit underrun |
| tx_disable | input | 1 | Transmitter disabled, sets the underrun bit |
| send_abort_cmd | input | 1 | Send-abort command pulse |
| clr_urun_cmd | input | 1 | Clears the underrun bit |
| clr_stat_cmd | input | 1 | Releases the pending interrupt and re-samples status |
| ie_brk | input | 1 | Break/abort enable |
| ie_urun | input | 1 | Underrun enable |
| ie_cts | input | 1 | Clear-to-send enable |
| ie_sync | input | 1 | Sync enable |
| stat_byte | output | 8 | Status byte |
| irq | output | 1 | Interrupt request, equal to the pending flag |

## Verification
Different results are due at different depths:
- A pin change reaches bit 5 or bit 4 through the synchronizer two edges later when the enable is clear. The pending flag and the latched bit change on the third edge.
- Break/abort edges and every command act one edge after they are sampled.

The bench drives inputs on falling edges and samples on the next falling edge after the edge where a result is due. It also compares against a cycle model that keeps its own two-stage pipeline and counts pin transitions with integers, so the parity rule is checked independently of the toggle flops. Random stimulus with a fixed seed then runs the model and the block side by side every cycle.

// File: rtl/xsl_pkg.sv
package xsl_pkg;
  localparam int STAT_W   = 8;
  localparam int BIT_BRK  = 7;
  localparam int BIT_URUN = 6;
  localparam int BIT_CTS  = 5;
  localparam int BIT_SYNC = 4;

  // how a level source decides to re-raise after release
  typedef enum logic {
    TRK_PARITY = 1'b0,
    TRK_ANY    = 1'b1
  } trk_mode_e;
endpackage

// File: rtl/xsl_sync.sv
module xsl_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= {STAGES{IDLE}};
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/xsl_level_track.sv
module xsl_level_track
  import xsl_pkg::*;
#(
  parameter trk_mode_e MODE = TRK_PARITY,
  parameter logic      IDLE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic ie,
  input  logic hold,
  output logic view,
  output logic req
);
  logic live_d, lat, acc, chg, acc_nx;

  assign chg = live ^ live_d;

  generate
    if (MODE == TRK_PARITY) begin : g_par
      assign acc_nx = acc ^ chg;
      // the toggle flop always equals "live moved away from the latch"
      assert_parity_track_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        acc == (lat ^ live_d));
    end else begin : g_any
      assign acc_nx = acc | chg;
      assert_edge_kept_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        hold && chg |=> acc);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_d <= IDLE;
      lat    <= IDLE;
      acc    <= 1'b0;
    end else begin
      live_d <= live;
      if (hold) begin
        acc <= acc_nx;
      end else begin
        acc <= 1'b0;
        lat <= live;
      end
    end
  end

  assign req  = ie & acc_nx;
  assign view = ie ? lat : live;

  assert_latch_frozen_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(lat));
endmodule

// File: rtl/xsl_urun_latch.sv
module xsl_urun_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic txdis,
  input  logic sabort,
  input  logic clr,
  input  logic ie,
  input  logic hold,
  output logic bit_q,
  output logic req
);
  logic set_w, rise, miss;

  assign set_w = evt | txdis | sabort;
  assign rise  = set_w & ~bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q <= 1'b1;
      miss  <= 1'b0;
    end else begin
      if (set_w)    bit_q <= 1'b1;
      else if (clr) bit_q <= 1'b0;
      miss <= hold ? (miss | rise) : 1'b0;
    end
  end

  assign req = ie & (miss | rise);

  assert_urun_set_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    set_w |=> bit_q);
  assert_urun_clear_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set_w |=> !bit_q);
  assert_urun_no_req_when_high_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(bit_q) && bit_q && !miss |-> !req);
endmodule

// File: rtl/xstat_irq_latch.sv
module xstat_irq_latch
  import xsl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brk_lvl,
  input  logic              cts_pin,
  input  logic              sync_pin,
  input  logic              urun_evt,
  input  logic              tx_disable,
  input  logic              send_abort_cmd,
  input  logic              clr_urun_cmd,
  input  logic              clr_stat_cmd,
  input  logic              ie_brk,
  input  logic              ie_urun,
  input  logic              ie_cts,
  input  logic              ie_sync,
  output logic [STAT_W-1:0] stat_byte,
  output logic              irq
);
  logic ip, hold;
  logic cts_s, sync_s;
  logic v_brk, v_cts, v_sync, v_urun;
  logic r_brk, r_cts, r_sync, r_urun, req_any;

  assign hold = ip & ~clr_stat_cmd;

  xsl_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync_cts (
    .clk(clk), .rst_n(rst_n), .d(cts_pin), .q(cts_s));
  xsl_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync_sync (
    .clk(clk), .rst_n(rst_n), .d(sync_pin), .q(sync_s));

  xsl_level_track #(.MODE(TRK_PARITY), .IDLE(1'b1)) u_trk_cts (
    .clk(clk), .rst_n(rst_n), .live(cts_s), .ie(ie_cts), .hold(hold),
    .view(v_cts), .req(r_cts));
  xsl_level_track #(.MODE(TRK_PARITY), .IDLE(1'b1)) u_trk_sync (
    .clk(clk), .rst_n(rst_n), .live(sync_s), .ie(ie_sync), .hold(hold),
    .view(v_sync), .req(r_sync));
  xsl_level_track #(.MODE(TRK_ANY), .IDLE(1'b0)) u_trk_brk (
    .clk(clk), .rst_n(rst_n), .live(brk_lvl), .ie(ie_brk), .hold(hold),
    .view(v_brk), .req(r_brk));

  xsl_urun_latch u_urun (
    .clk(clk), .rst_n(rst_n), .evt(urun_evt), .txdis(tx_disable),
    .sabort(send_abort_cmd), .clr(clr_urun_cmd), .ie(ie_urun), .hold(hold),
    .bit_q(v_urun), .req(r_urun));

  assign req_any = r_brk | r_cts | r_sync | r_urun;

  always_ff @(posedge clk) begin
    if (!rst_n)                    ip <= 1'b0;
    else if (!ip || clr_stat_cmd)  ip <= req_any;
  end

  always_comb begin
    stat_byte           = '0;
    stat_byte[BIT_BRK]  = v_brk;
    stat_byte[BIT_URUN] = v_urun;
    stat_byte[BIT_CTS]  = v_cts;
    stat_byte[BIT_SYNC] = v_sync;
  end

  assign irq = ip;

  assert_pending_held_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    ip && !clr_stat_cmd |=> ip);
  assert_irq_has_cause_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ip) |-> $past(req_any));
  assert_low_nibble_zero_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    stat_byte[3:0] == 4'h0);
endmodule

// File: tb/tb_xstat_irq_latch.sv
`timescale 1ns/1ps
module tb_xstat_irq_latch;
  logic clk = 1'b0, rst_n = 1'b0;
  logic brk_lvl = 0, cts_pin = 1, sync_pin = 1;
  logic urun_evt = 0, tx_disable = 0, send_abort_cmd = 0, clr_urun_cmd = 0, clr_stat_cmd = 0;
  logic ie_brk = 1, ie_urun = 1, ie_cts = 1, ie_sync = 1;
  logic [7:0] stat_byte;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  xstat_irq_latch dut (
    .clk(clk), .rst_n(rst_n), .brk_lvl(brk_lvl), .cts_pin(cts_pin), .sync_pin(sync_pin),
    .urun_evt(urun_evt), .tx_disable(tx_disable), .send_abort_cmd(send_abort_cmd),
    .clr_urun_cmd(clr_urun_cmd), .clr_stat_cmd(clr_stat_cmd), .ie_brk(ie_brk),
    .ie_urun(ie_urun), .ie_cts(ie_cts), .ie_sync(ie_sync), .stat_byte(stat_byte), .irq(irq));

  // reference model: two-stage pin pipeline, integer transition counters
  logic c1, c2, cprev, clat, s1, s2, sprev, slat, bprev, blat, m_urun, m_miss, m_ip;
  int cc, sc, bc;

  task automatic model_reset();
    c1 = 1; c2 = 1; cprev = 1; clat = 1; s1 = 1; s2 = 1; sprev = 1; slat = 1;
    bprev = 0; blat = 0; m_urun = 1; m_miss = 0; m_ip = 0; cc = 0; sc = 0; bc = 0;
  endtask

  task automatic model_step();
    logic lc, ls, lb, ec, es, eb, uset, rise, hold, rc, rs, rb, ru;
    lc = c2; ls = s2; lb = brk_lvl;
    ec = (lc != cprev); es = (ls != sprev); eb = (lb != bprev);
    uset = urun_evt | tx_disable | send_abort_cmd;
    rise = uset && !m_urun;
    hold = m_ip && !clr_stat_cmd;
    rc = ie_cts && (((cc + int'(ec)) % 2) == 1);
    rs = ie_sync && (((sc + int'(es)) % 2) == 1);
    rb = ie_brk && ((bc + int'(eb)) > 0);
    ru = ie_urun && (m_miss || rise);
    if (hold) begin
      cc += int'(ec); sc += int'(es); bc += int'(eb); m_miss = m_miss | rise;
    end else begin
      cc = 0; sc = 0; bc = 0; m_miss = 0;
      clat = lc; slat = ls; blat = lb;
      m_ip = rc | rs | rb | ru;
    end
    cprev = lc; c2 = c1; c1 = cts_pin;
    sprev = ls; s2 = s1; s1 = sync_pin;
    bprev = lb;
    m_urun = uset ? 1'b1 : (clr_urun_cmd ? 1'b0 : m_urun);
  endtask

  function automatic logic [8:0] model_out();
    logic [7:0] st;
    st = {ie_brk ? blat : brk_lvl, m_urun, ie_cts ? clat : c2, ie_sync ? slat : s2, 4'h0};
    return {m_ip, st};
  endfunction

  initial model_reset();
  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) chk("R2-model", {irq, stat_byte}, model_out());
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    ticks(3);
    rst_n = 1;
    // R1
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 status", stat_byte, 8'h70);
    // R2
    cts_pin = 0; ticks(2);
    chk("R2 not yet", {7'd0, irq}, 8'd0);
    tick();
    chk("R2 irq", {7'd0, irq}, 8'd1);
    chk("R2 bit5", {7'd0, stat_byte[5]}, 8'd0);
    // R3 / R4 odd toggle
    cts_pin = 1; ticks(4);
    chk("R3 frozen bit5", {7'd0, stat_byte[5]}, 8'd0);
    clr_stat_cmd = 1; tick();
    chk("R4 odd re-raise", {7'd0, irq}, 8'd1);
    chk("R9 resample bit5", {7'd0, stat_byte[5]}, 8'd1);
    tick(); clr_stat_cmd = 0;
    chk("R9 released", {7'd0, irq}, 8'd0);
    // R10 / R4 even toggles on sync
    sync_pin = 0; ticks(3);
    chk("R10 irq", {7'd0, irq}, 8'd1);
    sync_pin = 1; ticks(3); sync_pin = 0; ticks(3);
    chk("R10 frozen bit4", {7'd0, stat_byte[4]}, 8'd0);
    clr_stat_cmd = 1; tick(); clr_stat_cmd = 0;
    chk("R4 even drops", {7'd0, irq}, 8'd0);
    // R5
    ie_cts = 0; cts_pin = 0; tick();
    chk("R5 bit5 lag", {7'd0, stat_byte[5]}, 8'd1);
    tick();
    chk("R5 bit5 live", {7'd0, stat_byte[5]}, 8'd0);
    tick();
    chk("R5 no irq", {7'd0, irq}, 8'd0);
    cts_pin = 1; ticks(3); ie_cts = 1;
    // R6
    brk_lvl = 1; tick();
    chk("R6 rise irq", {7'd0, irq}, 8'd1);
    chk("R6 bit7", {7'd0, stat_byte[7]}, 8'd1);
    brk_lvl = 0; tick(); brk_lvl = 1; tick();
    clr_stat_cmd = 1; tick();
    chk("R6 even edges re-raise", {7'd0, irq}, 8'd1);
    tick(); clr_stat_cmd = 0;
    chk("R9 release brk", {7'd0, irq}, 8'd0);
    brk_lvl = 0; tick();
    chk("R6 fall irq", {7'd0, irq}, 8'd1);
    clr_stat_cmd = 1; tick(); clr_stat_cmd = 0;
    // R7 / R8
    clr_urun_cmd = 1; tick(); clr_urun_cmd = 0;
    chk("R7 cleared", {irq, stat_byte[6]}, 8'd0);
    urun_evt = 1; tick(); urun_evt = 0;
    chk("R8 rise irq", {irq, stat_byte[6]}, 8'd3);
    clr_stat_cmd = 1; tick(); clr_stat_cmd = 0;
    send_abort_cmd = 1; tick(); send_abort_cmd = 0;
    chk("R8 already high", {irq, stat_byte[6]}, 8'd1);
    clr_urun_cmd = 1; urun_evt = 1; tick(); clr_urun_cmd = 0; urun_evt = 0;
    chk("R7 set wins", {irq, stat_byte[6]}, 8'd1);
    clr_urun_cmd = 1; tick(); clr_urun_cmd = 0;
    tx_disable = 1; tick(); tx_disable = 0;
    chk("R7 tx disable", {irq, stat_byte[6]}, 8'd3);
    clr_stat_cmd = 1; tick(); clr_stat_cmd = 0;
    ie_urun = 0; clr_urun_cmd = 1; tick(); clr_urun_cmd = 0;
    send_abort_cmd = 1; tick(); send_abort_cmd = 0;
    chk("R8 disabled", {irq, stat_byte[6]}, 8'd1);
    ie_urun = 1;
    // random phase against the model
    cmp_on = 1;
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(5) == 0) cts_pin = ~cts_pin;
      if ($urandom_range(5) == 0) sync_pin = ~sync_pin;
      if ($urandom_range(7) == 0) brk_lvl = ~brk_lvl;
      clr_stat_cmd   = ($urandom_range(7) == 0);
      clr_urun_cmd   = ($urandom_range(11) == 0);
      urun_evt       = ($urandom_range(15) == 0);
      tx_disable     = ($urandom_range(23) == 0);
      send_abort_cmd = ($urandom_range(23) == 0);
      if ($urandom_range(49) == 0) ie_cts  = ~ie_cts;
      if ($urandom_range(49) == 0) ie_sync = ~ie_sync;
      if ($urandom_range(49) == 0) ie_brk  = ~ie_brk;
      if ($urandom_range(49) == 0) ie_urun = ~ie_urun;
      tick();
    end
    cmp_on = 0;
    finish_run();
  end
endmodule